// File: doc/BRIEF.md
# Coherence Request Fan-out and Response Counter

This block sits beside a shared last-level cache controller. It takes over when a write hits a line that other first-level caches also hold, or when a victim line that first-level caches may hold is being evicted. From a snapshot of the line's sharer record it sends coherence requests to the caches that hold copies. It then counts their one-flit replies and raises a one-cycle completion pulse. That pulse tells the controller it may acknowledge the original write, or finish the eviction.

The sharer record comes in one of two forms. In list form it is a bitmask with one bit per cache ID. Each set bit then gets its own request: updates for a write, invalidations for an eviction. For a write, the writer's own bit is skipped. In count form only the number of copies is known. The block then sends a single broadcast invalidate and waits for that many replies. All coherence requests are write-class traffic. Data payload and routing belong to the downstream network.

Top module: `coh_fanout`

## Requirements
- R1: A job is taken only when `job_ready` is high, and `job_ready` equals "not busy". A job presented while busy is ignored: it causes no requests and no second completion.
- R2: `busy` rises on the clock edge that takes a job and falls on the edge that raises `done`. `done` is high for exactly one cycle.
- R3: A write with a list-form record (`job_evict`=0, `job_count_mode`=0) sends one request per set bit of `job_sharers`, with bit `job_writer` cleared. These go out in ascending target ID order, with `req_type`=1 (update), `req_flits` = `job_words`+2, and `req_addr` equal to the job address on every request.
- R4: An eviction with a list-form record (`job_evict`=1) sends one request per set bit of `job_sharers`, including the writer's bit. These go out in ascending ID order, with `req_type`=2 (multicast invalidate) and `req_flits`=1.
- R5: A count-form job (`job_count_mode`=1), whether write or eviction, sends exactly one request with `req_type`=3 (broadcast invalidate), `req_target`=0 and `req_flits`=1.
- R6: The number of replies awaited is the number of requests sent in list form, or `job_count` in count form. `done` rises one cycle after the edge on which the last awaited reply is taken, provided every request has been sent.
- R7: When no replies are awaited and no request is to be sent, `done` rises on the cycle after the job is taken.
- R8: While `req_valid` is high and `req_ready` is low, the request fields hold their values.
- R9: `rsp_valid` while idle is ignored: it does not reduce the reply count of a later job.
- R10: Replies that arrive before all requests have been sent are counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| job_valid | input | 1 | Job offered |
| job_ready | output | 1 | Block idle, job will be taken |
| job_evict | input | 1 | 0 = write to shared line, 1 = eviction |
| job_count_mode | input | 1 | 0 = sharer bitmask valid, 1 = copy count only |
| job_sharers | input | NODES | Sharer bitmask, bit i = cache ID i |
| job_count | input | CW | Copy count for count form |
| job_writer | input | IW | Cache ID of the writer |
| job_words | input | WW | Data words carried by an update |
| job_addr | input | AW | Line address |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Request taken by network |
| req_target | output | IW | Destination cache ID |
| req_type | output | 2 | 1 update, 2 multicast invalidate, 3 broadcast invalidate |
| req_addr | output | AW | Line address |
| req_flits | output | FW | Command packet length in flits |
| rsp_valid | input | 1 | One single-flit reply received |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions take it as given that replies never outnumber the copies the job declared. A reply arriving while the counter reads zero during a job is therefore treated as an environment fault. They also assume that `job_writer` is below NODES. The stimulus sends exactly the awaited number of replies per job. Any stray reply it sends arrives only while the block is idle. All writer IDs it uses lie within the sharer mask width.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    REQ_NONE   = 2'd0,
    REQ_UPDATE = 2'd1,
    REQ_MINVAL = 2'd2,
    REQ_BINVAL = 2'd3
  } req_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } fan_state_e;
endpackage

// File: rtl/coh_pick.sv
module coh_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_sel
      if (g == 0) begin : g_first
        assign onehot[g] = mask[g];
      end else begin : g_rest
        assign onehot[g] = mask[g] & ~(|mask[g-1:0]);
      end
    end
  endgenerate

  assign any = |mask;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/coh_ack_ctr.sv
module coh_ack_ctr #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] remaining,
  output logic          zero
);
  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
    end else if (load) begin
      remaining <= load_val;
    end else if (dec) begin
      remaining <= remaining - CW'(1);
    end
  end

  assign zero = (remaining == '0);
endmodule

// File: rtl/coh_fanout.sv
module coh_fanout
  import coh_pkg::*;
#(
  parameter int NODES = 8,
  parameter int AW    = 32,
  parameter int WW    = 4,
  parameter int IW    = $clog2(NODES),
  parameter int CW    = $clog2(NODES + 1),
  parameter int FW    = WW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          job_valid,
  output logic          job_ready,
  input  logic          job_evict,
  input  logic          job_count_mode,
  input  logic [NODES-1:0] job_sharers,
  input  logic [CW-1:0] job_count,
  input  logic [IW-1:0] job_writer,
  input  logic [WW-1:0] job_words,
  input  logic [AW-1:0] job_addr,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [IW-1:0] req_target,
  output logic [1:0]    req_type,
  output logic [AW-1:0] req_addr,
  output logic [FW-1:0] req_flits,
  input  logic          rsp_valid,
  output logic          busy,
  output logic          done
);
  fan_state_e       st;
  logic [NODES-1:0] mask_q;
  logic             bcast_q;
  logic             evict_q;
  logic [IW-1:0]    writer_q;
  logic [WW-1:0]    words_q;
  logic [AW-1:0]    addr_q;

  logic             take;
  logic [NODES-1:0] job_mask;
  logic [CW-1:0]    job_expect;
  logic             pick_any;
  logic [IW-1:0]    pick_idx;
  logic [NODES-1:0] pick_oh;
  logic             ctr_dec;
  logic [CW-1:0]    ctr_rem;
  logic             ctr_zero;
  logic             hs;
  logic             all_sent;
  req_kind_e        kind_now;

  function automatic logic [CW-1:0] popc(input logic [NODES-1:0] v);
    logic [CW-1:0] s;
    s = '0;
    for (int i = 0; i < NODES; i++) s = s + CW'(v[i]);
    return s;
  endfunction

  assign take = job_valid && (st == ST_IDLE);

  always_comb begin
    job_mask = job_sharers;
    if (!job_evict) job_mask[job_writer] = 1'b0;
    job_expect = job_count_mode ? job_count : popc(job_mask);
  end

  coh_pick #(.N(NODES), .IW(IW)) u_pick (
    .mask   (mask_q),
    .any    (pick_any),
    .idx    (pick_idx),
    .onehot (pick_oh)
  );

  assign ctr_dec = rsp_valid && (st == ST_RUN) && !ctr_zero;

  coh_ack_ctr #(.CW(CW)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .load      (take),
    .load_val  (job_expect),
    .dec       (ctr_dec),
    .remaining (ctr_rem),
    .zero      (ctr_zero)
  );

  assign all_sent = !bcast_q && !pick_any;
  assign hs       = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      mask_q   <= '0;
      bcast_q  <= 1'b0;
      evict_q  <= 1'b0;
      writer_q <= '0;
      words_q  <= '0;
      addr_q   <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == ST_IDLE) begin
        if (take) begin
          st       <= ST_RUN;
          mask_q   <= job_count_mode ? '0 : job_mask;
          bcast_q  <= job_count_mode;
          evict_q  <= job_evict;
          writer_q <= job_writer;
          words_q  <= job_words;
          addr_q   <= job_addr;
        end
      end else begin
        if (hs) begin
          if (bcast_q) bcast_q <= 1'b0;
          else         mask_q  <= mask_q & ~pick_oh;
        end
        if (all_sent && ctr_zero) begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (bcast_q)      kind_now = REQ_BINVAL;
    else if (evict_q) kind_now = REQ_MINVAL;
    else              kind_now = REQ_UPDATE;
  end

  assign req_valid  = (st == ST_RUN) && (bcast_q || pick_any);
  assign req_target = bcast_q ? '0 : pick_idx;
  assign req_type   = kind_now;
  assign req_addr   = addr_q;
  assign req_flits  = (kind_now == REQ_UPDATE) ? ({1'b0, words_q} + FW'(2)) : FW'(1);
  assign busy       = (st == ST_RUN);
  assign job_ready  = (st == ST_IDLE);

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (job_valid && job_ready) |=> busy);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy));

  // R3
  writer_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_type == REQ_UPDATE) |-> (req_target != writer_q));

  // R6
  rsp_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && busy) |-> (ctr_rem != '0));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> req_valid && $stable(req_target) &&
                                  $stable(req_type) && $stable(req_flits));
endmodule

// File: tb/sim_coh_fanout.sv
`timescale 1ns/1ps
module sim_coh_fanout;
  localparam int NODES = 8;
  localparam int AW = 32;
  localparam int WW = 4;
  localparam int IW = 3;
  localparam int CW = 4;
  localparam int FW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic job_valid = 1'b0, job_evict = 1'b0, job_count_mode = 1'b0;
  logic [NODES-1:0] job_sharers = '0;
  logic [CW-1:0] job_count = '0;
  logic [IW-1:0] job_writer = '0;
  logic [WW-1:0] job_words = '0;
  logic [AW-1:0] job_addr = '0;
  logic req_ready = 1'b0, rsp_valid = 1'b0;
  logic job_ready, req_valid, busy, done;
  logic [IW-1:0] req_target;
  logic [1:0] req_type;
  logic [AW-1:0] req_addr;
  logic [FW-1:0] req_flits;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  coh_fanout #(.NODES(NODES), .AW(AW), .WW(WW)) u0 (
    .clk(clk), .rst(rst), .job_valid(job_valid), .job_ready(job_ready),
    .job_evict(job_evict), .job_count_mode(job_count_mode),
    .job_sharers(job_sharers), .job_count(job_count), .job_writer(job_writer),
    .job_words(job_words), .job_addr(job_addr), .req_valid(req_valid),
    .req_ready(req_ready), .req_target(req_target), .req_type(req_type),
    .req_addr(req_addr), .req_flits(req_flits), .rsp_valid(rsp_valid),
    .busy(busy), .done(done)
  );

  // {evict, count_mode, sharers[7:0], count[3:0], writer[2:0], words[3:0]}
  localparam logic [20:0] VEC [0:7] = '{
    {1'b0, 1'b0, 8'b0010_1101, 4'd0, 3'd2, 4'd4},
    {1'b1, 1'b0, 8'b1000_0110, 4'd0, 3'd1, 4'd3},
    {1'b0, 1'b1, 8'b0000_0000, 4'd6, 3'd0, 4'd2},
    {1'b1, 1'b1, 8'b1111_1111, 4'd8, 3'd5, 4'd1},
    {1'b0, 1'b0, 8'b0001_0000, 4'd0, 3'd4, 4'd7},
    {1'b0, 1'b0, 8'b0000_0000, 4'd0, 3'd3, 4'd2},
    {1'b0, 1'b0, 8'b1111_1111, 4'd0, 3'd7, 4'd15},
    {1'b1, 1'b0, 8'b0000_0001, 4'd0, 3'd0, 4'd5}
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic put_job(input logic ev, input logic cm, input logic [7:0] sh,
                         input logic [3:0] cnt, input logic [2:0] wr,
                         input logic [3:0] wd, input logic [31:0] ad);
    job_valid = 1'b1; job_evict = ev; job_count_mode = cm; job_sharers = sh;
    job_count = cnt; job_writer = wr; job_words = wd; job_addr = ad;
  endtask

  task automatic finish_job(input int nrsp);
    if (nrsp == 0) begin
      @(negedge clk);
      check(done == 1'b1, "R7 done after zero-reply job", done, 1);
    end else begin
      for (int i = 0; i < nrsp; i++) begin
        @(negedge clk); rsp_valid = 1'b1;
      end
      @(negedge clk); rsp_valid = 1'b0;
      check(done == 1'b0, "R6 done not before last reply seen", done, 0);
      @(negedge clk);
      check(done == 1'b1, "R6 done after last reply", done, 1);
    end
    check(busy == 1'b0, "R2 busy low with done", busy, 0);
    @(negedge clk);
    check(done == 1'b0, "R2 done single cycle", done, 0);
  endtask

  task automatic run_job(input logic ev, input logic cm, input logic [7:0] sh,
                         input logic [3:0] cnt, input logic [2:0] wr,
                         input logic [3:0] wd, input logic [31:0] ad);
    logic [7:0] m;
    int nrsp;
    m = sh;
    if (!ev) m[wr] = 1'b0;
    nrsp = cm ? int'(cnt) : $countones(m);
    req_ready = 1'b1;
    @(negedge clk);
    check(job_ready == 1'b1, "R1 ready when idle", job_ready, 1);
    put_job(ev, cm, sh, cnt, wr, wd, ad);
    @(negedge clk);
    job_valid = 1'b0;
    check(busy == 1'b1, "R2 busy after take", busy, 1);
    if (cm) begin
      check(req_valid == 1'b1, "R5 broadcast valid", req_valid, 1);
      check(req_type == 2'd3, "R5 broadcast type", req_type, 3);
      check(req_target == 3'd0, "R5 broadcast target", req_target, 0);
      check(req_flits == 5'd1, "R5 broadcast flits", req_flits, 1);
      check(req_addr == ad, "R5 broadcast addr", req_addr, ad);
      @(negedge clk);
    end else begin
      for (int b = 0; b < 8; b++) begin
        if (m[b]) begin
          check(req_valid == 1'b1, "R3 R4 request valid", req_valid, 1);
          check(req_target == 3'(b), "R3 R4 target order", req_target, b);
          if (ev) begin
            check(req_type == 2'd2, "R4 invalidate type", req_type, 2);
            check(req_flits == 5'd1, "R4 invalidate flits", req_flits, 1);
          end else begin
            check(req_type == 2'd1, "R3 update type", req_type, 1);
            check(req_flits == 5'(wd) + 5'd2, "R3 update flits", req_flits, wd + 2);
          end
          check(req_addr == ad, "R3 R4 constant addr", req_addr, ad);
          @(negedge clk);
        end
      end
    end
    check(req_valid == 1'b0, "R3 R4 R5 no extra request", req_valid, 0);
    finish_job(nrsp);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R2 reset busy", busy, 0);
    check(done == 1'b0, "R2 reset done", done, 0);
    check(req_valid == 1'b0, "R1 reset req_valid", req_valid, 0);
    check(job_ready == 1'b1, "R1 reset job_ready", job_ready, 1);

    for (int v = 0; v < 8; v++) begin
      run_job(VEC[v][20], VEC[v][19], VEC[v][18:11], VEC[v][10:7],
              VEC[v][6:4], VEC[v][3:0], 32'h4000_0000 + 32'(v) * 32'h40);
    end

    // R1 and R8: job offered while busy, request stalled
    req_ready = 1'b0;
    @(negedge clk);
    put_job(1'b0, 1'b0, 8'b1000_0011, 4'd0, 3'd7, 4'd1, 32'h55AA_0000);
    @(negedge clk);
    put_job(1'b1, 1'b1, 8'hFF, 4'd5, 3'd0, 4'd0, 32'h1234_5678);
    for (int i = 0; i < 3; i++) begin
      check(job_ready == 1'b0, "R1 not ready while busy", job_ready, 0);
      check(req_valid == 1'b1 && req_target == 3'd0, "R8 stalled target held", req_target, 0);
      check(req_addr == 32'h55AA_0000, "R8 stalled addr held", req_addr, 32'h55AA_0000);
      @(negedge clk);
    end
    job_valid = 1'b0;
    req_ready = 1'b1;
    @(negedge clk);
    check(req_target == 3'd1 && req_type == 2'd1, "R1 second request of first job", req_target, 1);
    @(negedge clk);
    check(req_valid == 1'b0, "R1 ignored job sent nothing", req_valid, 0);
    finish_job(2);
    repeat (2) begin
      check(busy == 1'b0 && req_valid == 1'b0, "R1 ignored job never started", busy, 0);
      @(negedge clk);
    end

    // R10: replies before the broadcast leaves
    req_ready = 1'b0;
    put_job(1'b0, 1'b1, 8'h00, 4'd3, 3'd2, 4'd1, 32'h0000_0F00);
    @(negedge clk);
    job_valid = 1'b0;
    rsp_valid = 1'b1;
    repeat (3) @(negedge clk);
    rsp_valid = 1'b0;
    check(busy == 1'b1 && req_valid == 1'b1, "R10 waiting on request", busy, 1);
    req_ready = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R10 done not before request sent", done, 0);
    @(negedge clk);
    check(done == 1'b1, "R10 early replies counted", done, 1);
    @(negedge clk);

    // R9: stray replies while idle
    rsp_valid = 1'b1;
    repeat (2) @(negedge clk);
    rsp_valid = 1'b0;
    put_job(1'b1, 1'b0, 8'b0100_0000, 4'd0, 3'd0, 4'd0, 32'h0000_7700);
    @(negedge clk);
    job_valid = 1'b0;
    check(req_target == 3'd6 && req_type == 2'd2, "R9 single invalidate", req_target, 6);
    @(negedge clk);
    repeat (3) begin
      check(busy == 1'b1 && done == 1'b0, "R9 idle replies not counted", done, 0);
      @(negedge clk);
    end
    finish_job(1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule